// File: doc/BRIEF.md
# Real-Time Clock with Alarm, Wrap Warning and Periodic Timer

This block keeps time for a chip. A 40-bit time counter moves forward by one on every slow tick enable. A 40-bit alarm value and a 40-bit warning threshold are both compared against the counter. A 16-bit periodic timer counts down on a faster tick enable and reloads itself each time it expires. Three separate sticky interrupt lines report three events: the alarm being reached, the periodic timer expiring, and the counter getting close to wrapping past its top value.

Software uses a write-only register port. Each write selects a target with a 3-bit select code. The time counter, the threshold values and the status bits are all visible on output ports. The ticks are single-cycle enables in the block's own clock domain, so the block does no clock-domain crossing.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the time counter is 0, the timer count is 0, the timer is idle, all three interrupt outputs are 0, the alarm value is 0 and the warning threshold is 2^40-1-2^16 (0xFFFFFEFFFF).
- R2: On each clock edge with `slow_tick` high and no counter write, the time counter increases by one and wraps from all ones to zero. With no tick and no write it holds its value.
- R3: A write with select 0 loads `reg_wdata` into the time counter on that edge. The write takes priority over a tick in the same cycle, and it never sets the alarm or warning status, even when the loaded value equals the alarm value or the threshold.
- R4: Select 1 writes the alarm value. `irq_alarm` goes high on the edge where a tick moves the counter onto the alarm value (compared against the alarm value held before that edge). It is set once per match and stays high until cleared.
- R5: Select 3 writes the warning threshold. `irq_warn` goes high on the edge where a tick moves the counter onto the threshold, so it warns before the wrap.
- R6: A write with select 2 and a nonzero value N (bits 15:0) stores N as the reload value, loads the timer count with N and starts the timer. Each `fast_tick` lowers the count by one. A tick seen at count 1 sets `irq_timer` and reloads N, so the timer expires once every N fast ticks.
- R7: A write with select 2 and value 0 stops the timer and sets its count to 0. While stopped, fast ticks change nothing and raise no timer interrupt.
- R8: A write with select 4 clears the status bits whose data bits are 1: bit 0 alarm, bit 1 timer, bit 2 warning. Bits written as 0 are kept. If an event and a clear of the same bit fall in one cycle, the bit ends up set.
- R9: Writes with select 5, 6 or 7 change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Time counter advance enable |
| fast_tick | input | 1 | Periodic timer decrement enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write target select |
| reg_wdata | input | 40 | Write data |
| time_count | output | 40 | Current time counter value |
| timer_count | output | 16 | Current periodic timer count |
| irq_alarm | output | 1 | Sticky alarm interrupt |
| irq_timer | output | 1 | Sticky periodic expiry interrupt |
| irq_warn | output | 1 | Sticky pre-wrap warning interrupt |

## Verification
Every result is registered exactly once. A counter load, a timer reload, a tick step, an interrupt set and an interrupt clear all show up on the ports after the first rising edge that samples the stimulus. The bench drives inputs on the falling edge. After each rising edge it advances its own model by one step and compares every output 1 ns later. The count, the timer and the status bits are therefore always checked in the cycle in which they are due, never one cycle early or late.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        SEL_COUNT  = 3'd0,
        SEL_ALARM  = 3'd1,
        SEL_RELOAD = 3'd2,
        SEL_WARN   = 3'd3,
        SEL_CLEAR  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        TMR_IDLE,
        TMR_RUN
    } tmr_state_e;

    // bit 0 alarm, bit 1 timer, bit 2 warning
    typedef struct packed {
        logic warn;
        logic timer;
        logic alarm;
    } irq_vec_t;

endpackage

// File: rtl/rtc_time_base.sv
module rtc_time_base
    import rtc_pkg::*;
#(
    parameter int CNT_W      = 40,
    parameter int WARN_LEAD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             ld_count,
    input  logic             ld_alarm,
    input  logic             ld_warn,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             alarm_hit,
    output logic             warn_hit
);
    localparam logic [CNT_W-1:0] WARN_DEFAULT = {CNT_W{1'b1}} - (CNT_W'(1) << WARN_LEAD);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] warn_q;
    logic [CNT_W-1:0] count_inc;
    logic             advance;

    assign count_inc = count_q + CNT_W'(1);
    assign advance   = slow_tick && !ld_count;

    // events only come from a tick moving onto a value, never from a load
    always_comb begin
        alarm_hit = advance && (count_inc == alarm_q);
        warn_hit  = advance && (count_inc == warn_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            alarm_q <= '0;
            warn_q  <= WARN_DEFAULT;
        end else begin
            if (ld_count)     count_q <= wdata;
            else if (advance) count_q <= count_inc;
            if (ld_alarm)     alarm_q <= wdata;
            if (ld_warn)      warn_q  <= wdata;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
    import rtc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_tick,
    input  logic             ld_reload,
    input  logic [TMR_W-1:0] reload_in,
    output logic [TMR_W-1:0] tmr_count,
    output logic             expire
);
    tmr_state_e       state_q, state_d;
    logic [TMR_W-1:0] reload_q;
    logic [TMR_W-1:0] cnt_q;
    logic             reload_zero;

    assign reload_zero = (reload_in == '0);

    // next-state logic: IDLE->RUN on nonzero reload, RUN->IDLE on zero reload
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (ld_reload && !reload_zero) state_d = TMR_RUN;
            TMR_RUN:  if (ld_reload &&  reload_zero) state_d = TMR_IDLE;
            default:  state_d = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_comb begin
        expire = (state_q == TMR_RUN) && fast_tick && !ld_reload && (cnt_q == TMR_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (ld_reload) begin
            reload_q <= reload_in;
            cnt_q    <= reload_in;
        end else if ((state_q == TMR_RUN) && fast_tick) begin
            cnt_q <= (cnt_q == TMR_W'(1)) ? reload_q : cnt_q - TMR_W'(1);
        end
    end

    assign tmr_count = cnt_q;

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t set_ev,
    input  logic     clr_we,
    input  irq_vec_t clr_mask,
    output irq_vec_t status
);
    irq_vec_t status_q;
    irq_vec_t keep;

    assign keep = clr_we ? ~clr_mask : '1;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & keep) | set_ev;
    end

    assign status = status_q;

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
    import rtc_pkg::*;
#(
    parameter int CNT_W     = 40,
    parameter int TMR_W     = 16,
    parameter int WARN_LEAD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             fast_tick,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] time_count,
    output logic [TMR_W-1:0] timer_count,
    output logic             irq_alarm,
    output logic             irq_timer,
    output logic             irq_warn
);
    logic     ld_count, ld_alarm, ld_warn, ld_reload, clr_we;
    logic     alarm_hit, warn_hit, expire;
    irq_vec_t set_ev, clr_mask, status;

    always_comb begin
        ld_count  = reg_we && (reg_addr == SEL_COUNT);
        ld_alarm  = reg_we && (reg_addr == SEL_ALARM);
        ld_reload = reg_we && (reg_addr == SEL_RELOAD);
        ld_warn   = reg_we && (reg_addr == SEL_WARN);
        clr_we    = reg_we && (reg_addr == SEL_CLEAR);
    end

    rtc_time_base #(.CNT_W(CNT_W), .WARN_LEAD(WARN_LEAD)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .ld_count  (ld_count),
        .ld_alarm  (ld_alarm),
        .ld_warn   (ld_warn),
        .wdata     (reg_wdata),
        .count     (time_count),
        .alarm_hit (alarm_hit),
        .warn_hit  (warn_hit)
    );

    rtc_periodic #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .ld_reload (ld_reload),
        .reload_in (reg_wdata[TMR_W-1:0]),
        .tmr_count (timer_count),
        .expire    (expire)
    );

    assign set_ev   = '{warn: warn_hit, timer: expire, alarm: alarm_hit};
    assign clr_mask = irq_vec_t'(reg_wdata[2:0]);

    rtc_irq_status u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .status   (status)
    );

    assign irq_alarm = status.alarm;
    assign irq_timer = status.timer;
    assign irq_warn  = status.warn;

endmodule

// File: rtl/rtc_alarm_timer_sva.sv
module rtc_alarm_timer_sva #(
    parameter int CNT_W = 40,
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_tick,
    input logic             fast_tick,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] time_count,
    input logic [TMR_W-1:0] timer_count,
    input logic             irq_alarm,
    input logic             irq_timer,
    input logic             irq_warn
);
    logic wr_cnt, wr_rel, wr_clr;
    assign wr_cnt = reg_we && (reg_addr == 3'd0);
    assign wr_rel = reg_we && (reg_addr == 3'd2);
    assign wr_clr = reg_we && (reg_addr == 3'd4);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && !wr_cnt) |=> (time_count == $past(time_count) + CNT_W'(1))); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_tick && !wr_cnt) |=> $stable(time_count)); // R2
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (time_count == $past(reg_wdata))); // R3
    AST_ALARM_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_alarm) |-> ($past(slow_tick) && !$past(wr_cnt))); // R4
    AST_TIMER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_tick && !wr_rel && (timer_count > TMR_W'(1))) |=> (timer_count == $past(timer_count) - TMR_W'(1))); // R6
    AST_TIMER_IRQ_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_timer) |-> $past(fast_tick)); // R6
    AST_TIMER_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((timer_count == '0) && !wr_rel) |=> ((timer_count == '0) && !$rose(irq_timer))); // R7
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_alarm && !(wr_clr && reg_wdata[0])) |=> irq_alarm); // R8
    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_warn && !(wr_clr && reg_wdata[2])) |=> irq_warn); // R8

endmodule

bind rtc_alarm_timer rtc_alarm_timer_sva #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick   (slow_tick),
    .fast_tick   (fast_tick),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .time_count  (time_count),
    .timer_count (timer_count),
    .irq_alarm   (irq_alarm),
    .irq_timer   (irq_timer),
    .irq_warn    (irq_warn)
);

// File: tb/rtc_alarm_timer_tb.sv
module rtc_alarm_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0, reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [39:0] reg_wdata = '0;
    logic [39:0] time_count;
    logic [15:0] timer_count;
    logic        irq_alarm, irq_timer, irq_warn;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    logic [39:0] m_cnt, m_alarm, m_warn;
    logic [15:0] m_rel, m_tmr;
    logic        m_ia, m_it, m_iw;

    always #10 clk = ~clk; // 50 MHz

    rtc_alarm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .time_count(time_count), .timer_count(timer_count),
        .irq_alarm(irq_alarm), .irq_timer(irq_timer), .irq_warn(irq_warn)
    );

    function automatic logic [15:0] next_tmr(input logic [15:0] t, input logic [15:0] r,
                                             input logic f);
        if (t == 16'd0 || !f) return t;
        return (t == 16'd1) ? r : t - 16'd1;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_alarm = '0; m_warn = 40'hFF_FFFE_FFFF;
        m_rel = '0; m_tmr = '0; m_ia = 0; m_it = 0; m_iw = 0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [39:0] d,
                              input logic s, input logic f);
        logic adv, a_ev, w_ev, t_ev, clr;
        adv  = s && !(we && a == 3'd0);
        a_ev = adv && (m_cnt + 40'd1 == m_alarm);
        w_ev = adv && (m_cnt + 40'd1 == m_warn);
        t_ev = !(we && a == 3'd2) && f && (m_tmr == 16'd1);
        clr  = we && a == 3'd4;
        m_ia = (m_ia && !(clr && d[0])) || a_ev;
        m_it = (m_it && !(clr && d[1])) || t_ev;
        m_iw = (m_iw && !(clr && d[2])) || w_ev;
        if (we && a == 3'd0) m_cnt = d; else if (adv) m_cnt = m_cnt + 40'd1;
        if (we && a == 3'd2) begin m_rel = d[15:0]; m_tmr = d[15:0]; end
        else m_tmr = next_tmr(m_tmr, m_rel, f);
        if (we && a == 3'd1) m_alarm = d;
        if (we && a == 3'd3) m_warn = d;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, "/R2"}, "time_count", time_count, m_cnt);
        check({tag, "/R6"}, "timer_count", {24'd0, timer_count}, {24'd0, m_tmr});
        check({tag, "/R4"}, "irq_alarm", {39'd0, irq_alarm}, {39'd0, m_ia});
        check({tag, "/R6"}, "irq_timer", {39'd0, irq_timer}, {39'd0, m_it});
        check({tag, "/R5"}, "irq_warn", {39'd0, irq_warn}, {39'd0, m_iw});
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [39:0] d,
                        input logic s, input logic f, input string tag);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; slow_tick = s; fast_tick = f;
        @(posedge clk);
        #1;
        model_step(we, a, d, s, f);
        compare_all(tag);
    endtask

    task automatic idle(input logic s, input logic f, input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 40'd0, s, f, tag);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 compare_all("R1");
        idle(0, 0, 1, "R1");

        // R3: load counter, priority over tick, load onto alarm does not fire
        step(1, 3'd1, 40'd50, 0, 0, "R4");
        step(1, 3'd0, 40'd50, 1, 0, "R3");
        step(1, 3'd0, 40'd49, 0, 0, "R3");
        // R4: alarm on advance, once per match
        idle(1, 0, 3, "R4");
        step(1, 3'd4, 40'd1, 0, 0, "R8");
        idle(1, 0, 4, "R4");
        // R2: wrap
        step(1, 3'd0, 40'hFF_FFFF_FFFE, 0, 0, "R3");
        idle(1, 0, 3, "R2");
        // R5: default threshold then programmed threshold
        step(1, 3'd0, 40'hFF_FFFE_FFFC, 0, 0, "R5");
        idle(1, 0, 4, "R5");
        step(1, 3'd3, 40'd20, 0, 0, "R5");
        step(1, 3'd0, 40'd20, 0, 0, "R5");
        step(1, 3'd0, 40'd18, 1, 0, "R5");
        idle(1, 0, 3, "R5");
        step(1, 3'd4, 40'd7, 0, 0, "R8");
        // R6: periodic timer period 3, and period 1
        step(1, 3'd2, 40'd3, 0, 1, "R6");
        idle(0, 1, 7, "R6");
        step(1, 3'd4, 40'd2, 0, 1, "R8");
        step(1, 3'd2, 40'd1, 0, 0, "R6");
        idle(0, 1, 3, "R6");
        // R7: stop
        step(1, 3'd2, 40'd0, 0, 1, "R7");
        step(1, 3'd4, 40'd2, 0, 1, "R7");
        idle(0, 1, 5, "R7");
        // R8: set beats clear; partial clear keeps other bits
        step(1, 3'd1, 40'd30, 0, 0, "R8");
        step(1, 3'd0, 40'd28, 0, 0, "R8");
        step(1, 3'd2, 40'd2, 1, 0, "R8");
        step(1, 3'd4, 40'd1, 1, 1, "R8");
        step(1, 3'd4, 40'd1, 0, 1, "R8");
        step(1, 3'd4, 40'd4, 0, 0, "R8");
        // R9: unused selects
        step(1, 3'd5, 40'hFF_FFFF_FFFF, 0, 0, "R9");
        step(1, 3'd6, 40'h12_3456_789A, 0, 0, "R9");
        step(1, 3'd7, 40'h00_0000_0007, 0, 0, "R9");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [2:0]  a;
            logic [39:0] d;
            we = ($urandom % 6) == 0;
            a  = 3'($urandom % 8);
            unique case (a)
                3'd0: d = 40'($urandom % 200);
                3'd1: d = m_cnt + 40'($urandom % 12);
                3'd2: d = 40'($urandom % 7);
                3'd3: d = m_cnt + 40'($urandom % 12);
                default: d = {8'($urandom), $urandom};
            endcase
            step(we, a, d, ($urandom % 3) == 0, $urandom % 2, "RND");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule